// File: doc/BRIEF.md
# Two-Level Trigger Latency Buffer

This block sits behind the discriminators of a strip readout chip. Every bunch-crossing clock it writes one word, holding one hit bit per channel, into a circular pipeline memory. While a first-level decision is pending, the sample stays in that memory until it is overwritten a full pipeline depth later.

When a first-level accept arrives, the block looks back by a programmed number of crossings. It copies that past word into a small addressable event store and tags it with an 8-bit event number taken from a running counter.

Second-level or regional requests arrive later, with no fixed delay, and name an event number. The block searches the store for that tag, not the oldest entry. It presents the result on a valid/ready output towards the compression and serializer stage. A request that finds nothing still returns an answer, flagged as a miss with an empty payload. A stored event is released only when its handshake completes.

Top module: `trig_latency_buffer`

## Requirements
- R1: Each clock out of reset the pipeline stores `hits_in` at a write position that advances by one and wraps at `PIPE_DEPTH`. The pipeline keeps working correctly after any number of wraps.
- R2: An accept raised in cycle c with `lat_cfg` = L captures the `hits_in` word presented in cycle c−L. L must lie in 1..`PIPE_DEPTH`−1.
- R3: A captured event can be requested from the cycle after its accept onward. A request in the same cycle as the accept does not see it.
- R4: A request raised while `evt_valid` is low produces `evt_valid` high in the next cycle, with `evt_id` equal to the requested number.
- R5: Events are found by their tag, in any order, independent of the order in which they were accepted.
- R6: A request whose number matches no stored event answers in the next cycle with `evt_miss`=1 and `evt_data` all zero.
- R7: While `evt_valid` is high and `evt_ready` is low, `evt_id`, `evt_miss` and `evt_data` hold. A request made while `evt_valid` is high is ignored and removes nothing from the store.
- R8: With `EVT_SLOTS` events stored, a further accept is discarded and sets `overflow`. `overflow` stays high until reset.
- R9: The first accept after reset is tagged 0. Every accept, including a discarded one, advances the tag by one modulo 256.
- R10: A hit frees its slot at the clock edge where `evt_valid` and `evt_ready` are both high. A repeated request for the same number then misses, and the slot can be refilled.
- R11: Synchronous reset clears the write position, the tag counter, every stored event, `evt_valid` and `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| lat_cfg | input | clog2(PIPE_DEPTH) | Look-back distance in crossings (1..PIPE_DEPTH−1) |
| hits_in | input | CH | One hit bit per channel for this crossing |
| l1_accept | input | 1 | First-level accept strobe |
| l2_req | input | 1 | Second-level / regional request strobe |
| l2_id | input | 8 | Event number requested |
| evt_valid | output | 1 | Output event present |
| evt_ready | input | 1 | Downstream takes the output event |
| evt_id | output | 8 | Event number of the output |
| evt_miss | output | 1 | Requested number was not stored |
| evt_data | output | CH | Captured hit word (zero on miss) |
| overflow | output | 1 | Sticky: an accept was discarded because the store was full |

## Verification
The bench builds the block with 32 channels, a 16-deep pipeline and a 4-slot store. At that size the write position wraps many times within a short run, and both ends of the latency range (1 and 15) can be exercised. The store fills after four accepts, so the discard path and the sticky flag come up early. More than 256 accept/request pairs push the tag counter through its wrap. Requests are issued out of order, for absent numbers, in the same cycle as an accept, and under output backpressure.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int EVT_ID_W = 8;
  typedef logic [EVT_ID_W-1:0] evt_id_t;

  // position reached by stepping back 'lag' entries from 'wr' in a ring of 'depth'
  function automatic int lag_index(int wr, int lag, int depth);
    return (wr + depth - lag) % depth;
  endfunction

  // next position in a ring of 'depth'
  function automatic int step_index(int idx, int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/tlb_pipe.sv
module tlb_pipe import tlb_pkg::*; #(
  parameter int CH    = 256,
  parameter int DEPTH = 256,
  localparam int PA_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH-1:0]   hits_in,
  input  logic [PA_W-1:0] lat,
  output logic [CH-1:0]   sample
);
  logic [CH-1:0]   mem [DEPTH];
  logic [PA_W-1:0] wr_ptr;
  logic [PA_W-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    mem[wr_ptr] <= hits_in;
    if (rst) wr_ptr <= '0;
    else     wr_ptr <= PA_W'(step_index(int'(wr_ptr), DEPTH));
  end

  assign rd_ptr = PA_W'(lag_index(int'(wr_ptr), int'(lat), DEPTH));
  assign sample = mem[rd_ptr];

  // R1
  wr_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(wr_ptr) == ($past(int'(wr_ptr)) + 1) % DEPTH));
endmodule

// File: rtl/tlb_idgen.sv
module tlb_idgen import tlb_pkg::*; (
  input  logic    clk,
  input  logic    rst,
  input  logic    bump,
  output evt_id_t cur_id
);
  always_ff @(posedge clk) begin
    if (rst)       cur_id <= '0;
    else if (bump) cur_id <= cur_id + 1'b1;
  end

  // R9
  id_step_chk: assert property (@(posedge clk) disable iff (rst)
    bump |=> cur_id == evt_id_t'($past(cur_id) + 1'b1));
  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bump |=> $stable(cur_id));
endmodule

// File: rtl/tlb_store.sv
module tlb_store import tlb_pkg::*; #(
  parameter int CH  = 256,
  parameter int ENT = 8,
  localparam int IX_W = (ENT > 1) ? $clog2(ENT) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_req,
  input  evt_id_t         alloc_id,
  input  logic [CH-1:0]   alloc_data,
  input  evt_id_t         look_id,
  output logic            look_hit,
  output logic [IX_W-1:0] look_idx,
  output logic [CH-1:0]   look_data,
  input  logic            free_en,
  input  logic [IX_W-1:0] free_idx,
  output logic            full,
  output logic            overflow
);
  logic [ENT-1:0] vld;
  logic [ENT-1:0] match_map;
  logic [ENT-1:0] grant;
  evt_id_t        tag_a  [ENT];
  logic [CH-1:0]  body_a [ENT];
  logic           alloc_fire;
  logic           drop;
  logic           granted;

  assign full       = &vld;
  assign alloc_fire = alloc_req && !full;
  assign drop       = alloc_req && full;

  // lowest free slot wins
  always_comb begin
    grant   = '0;
    granted = 1'b0;
    for (int i = 0; i < ENT; i++) begin
      if (!vld[i] && !granted) begin
        grant[i] = 1'b1;
        granted  = 1'b1;
      end
    end
  end

  // lowest matching slot wins
  always_comb begin
    look_hit = 1'b0;
    look_idx = '0;
    for (int i = 0; i < ENT; i++) begin
      if (match_map[i] && !look_hit) begin
        look_hit = 1'b1;
        look_idx = IX_W'(i);
      end
    end
  end

  assign look_data = body_a[look_idx];

  for (genvar g = 0; g < ENT; g++) begin : g_slot
    logic          v;
    evt_id_t       t;
    logic [CH-1:0] b;
    always_ff @(posedge clk) begin
      if (rst)                                  v <= 1'b0;
      else if (alloc_fire && grant[g])          v <= 1'b1;
      else if (free_en && free_idx == IX_W'(g)) v <= 1'b0;
      if (alloc_fire && grant[g]) begin
        t <= alloc_id;
        b <= alloc_data;
      end
    end
    assign vld[g]       = v;
    assign tag_a[g]     = t;
    assign body_a[g]    = b;
    assign match_map[g] = v && (t == look_id);
  end

  always_ff @(posedge clk) begin
    if (rst)       overflow <= 1'b0;
    else if (drop) overflow <= 1'b1;
  end

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && full && !free_en) |=> $stable(vld));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(alloc_req && full));
  // R3
  occupancy_up_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !full && !free_en) |=> $countones(vld) == $past($countones(vld)) + 1);
  // R10
  free_target_chk: assert property (@(posedge clk) disable iff (rst)
    free_en |-> vld[free_idx]);
endmodule

// File: rtl/trig_latency_buffer.sv
module trig_latency_buffer import tlb_pkg::*; #(
  parameter int CH         = 256,
  parameter int PIPE_DEPTH = 256,
  parameter int EVT_SLOTS  = 8,
  localparam int PA_W = (PIPE_DEPTH > 1) ? $clog2(PIPE_DEPTH) : 1,
  localparam int IX_W = (EVT_SLOTS > 1) ? $clog2(EVT_SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PA_W-1:0]     lat_cfg,
  input  logic [CH-1:0]       hits_in,
  input  logic                l1_accept,
  input  logic                l2_req,
  input  logic [EVT_ID_W-1:0] l2_id,
  output logic                evt_valid,
  input  logic                evt_ready,
  output logic [EVT_ID_W-1:0] evt_id,
  output logic                evt_miss,
  output logic [CH-1:0]       evt_data,
  output logic                overflow
);
  logic [CH-1:0]   sample;
  evt_id_t         cur_id;
  logic            look_hit;
  logic [IX_W-1:0] look_idx;
  logic [CH-1:0]   look_data;
  logic            full;
  logic [IX_W-1:0] held_idx;
  logic            take;
  logic            handshake;
  logic            free_en;

  assign take      = l2_req && !evt_valid;
  assign handshake = evt_valid && evt_ready;
  assign free_en   = handshake && !evt_miss;

  tlb_pipe #(.CH(CH), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst(rst), .hits_in(hits_in), .lat(lat_cfg), .sample(sample)
  );

  tlb_idgen u_idgen (
    .clk(clk), .rst(rst), .bump(l1_accept), .cur_id(cur_id)
  );

  tlb_store #(.CH(CH), .ENT(EVT_SLOTS)) u_store (
    .clk(clk), .rst(rst),
    .alloc_req(l1_accept), .alloc_id(cur_id), .alloc_data(sample),
    .look_id(l2_id), .look_hit(look_hit), .look_idx(look_idx), .look_data(look_data),
    .free_en(free_en), .free_idx(held_idx),
    .full(full), .overflow(overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid <= 1'b0;
      evt_id    <= '0;
      evt_miss  <= 1'b0;
      evt_data  <= '0;
      held_idx  <= '0;
    end else if (take) begin
      evt_valid <= 1'b1;
      evt_id    <= l2_id;
      evt_miss  <= !look_hit;
      evt_data  <= look_hit ? look_data : '0;
      held_idx  <= look_idx;
    end else if (handshake) begin
      evt_valid <= 1'b0;
    end
  end

  // R4
  req_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (l2_req && !evt_valid) |=> evt_valid && evt_id == $past(l2_id));
  // R6
  miss_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_miss) |-> evt_data == '0);
  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_ready) |=> evt_valid && $stable(evt_id) && $stable(evt_data) && $stable(evt_miss));
  // R10
  drain_out_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_ready) |=> !evt_valid);
endmodule

// File: tb/trig_latency_buffer_test.sv
`timescale 1ns/1ps
module trig_latency_buffer_test;
  localparam int CH = 32, DEPTH = 16, SLOTS = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic [3:0]    lat_cfg;
  logic [CH-1:0] hits_in;
  logic          l1_accept, l2_req, evt_ready;
  logic [7:0]    l2_id;
  logic          evt_valid, evt_miss, overflow;
  logic [7:0]    evt_id;
  logic [CH-1:0] evt_data;

  trig_latency_buffer #(.CH(CH), .PIPE_DEPTH(DEPTH), .EVT_SLOTS(SLOTS)) uut (
    .clk(clk), .rst(rst), .lat_cfg(lat_cfg), .hits_in(hits_in),
    .l1_accept(l1_accept), .l2_req(l2_req), .l2_id(l2_id),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_id(evt_id),
    .evt_miss(evt_miss), .evt_data(evt_data), .overflow(overflow)
  );

  typedef struct {
    logic [7:0]    id;
    logic          miss;
    logic [CH-1:0] data;
    string         tag;
  } exp_t;

  exp_t          sbq[$];
  logic [CH-1:0] model [int];
  logic [CH-1:0] hist  [int];
  int k, idc, checks, fails, cyc;
  bit exp_ovf, done;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one crossing: inputs held for cycle k, expectations pushed, then past the edge
  task automatic step(logic [CH-1:0] h, bit l1, bit l2, logic [7:0] id, string tag);
    exp_t e;
    hits_in = h; l1_accept = l1; l2_req = l2; l2_id = id;
    hist[k] = h;
    if (l2 && !evt_valid) begin
      e.id = id; e.tag = tag;
      if (model.exists(int'(id))) begin e.miss = 1'b0; e.data = model[int'(id)]; end
      else begin e.miss = 1'b1; e.data = '0; end
      sbq.push_back(e);
    end
    if (l1) begin
      if (model.num() < SLOTS) model[idc] = hist[k - int'(lat_cfg)];
      else exp_ovf = 1'b1;
      idc = (idc + 1) % 256;
    end
    k++;
    @(posedge clk); #1;
    l1_accept = 1'b0; l2_req = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(CH'($urandom), 1'b0, 1'b0, 8'h0, "");
  endtask

  task automatic drain();
    int n = 0;
    while ((sbq.size() != 0 || evt_valid) && n < 50) begin idle(1); n++; end
  endtask

  task automatic request(logic [7:0] id, string tag);
    step(CH'($urandom), 1'b0, 1'b1, id, tag);
    drain();
  endtask

  task automatic accept(output logic [7:0] id);
    id = 8'(idc);
    step(CH'($urandom), 1'b1, 1'b0, 8'h0, "");
  endtask

  // scoreboard monitor: compares at the half cycle before the handshake edge
  always @(negedge clk) begin
    exp_t e;
    if (!rst && evt_valid && evt_ready) begin
      if (sbq.size() == 0) chk(1'b0, "R4", "unexpected event id", 64'(evt_id), 64'h0);
      else begin
        e = sbq.pop_front();
        chk(evt_id == e.id, e.tag, "evt_id", 64'(evt_id), 64'(e.id));
        chk(evt_miss == e.miss, e.tag, "evt_miss", 64'(evt_miss), 64'(e.miss));
        chk(evt_data == e.data, e.tag, "evt_data", 64'(evt_data), 64'(e.data));
        if (!e.miss) model.delete(int'(e.id));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog R1..: run did not finish actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b, c, d;
    logic [7:0] ids[5];
    rst = 1'b1; lat_cfg = 4'd5; hits_in = '0; l1_accept = 1'b0; l2_req = 1'b0;
    l2_id = '0; evt_ready = 1'b1; k = 0; idc = 0; exp_ovf = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; k = 0;

    // R11 reset state
    chk(evt_valid == 1'b0, "R11", "evt_valid after reset", 64'(evt_valid), 64'h0);
    chk(overflow == 1'b0, "R11", "overflow after reset", 64'(overflow), 64'h0);

    // R1 run past several wraps, then R2/R3 capture and fetch
    idle(40);
    accept(a);
    chk(a == 8'd0, "R9", "first tag", 64'(a), 64'h0);
    request(a, "R3");

    // R5 out-of-order retrieval
    accept(a); idle(2); accept(b); idle(3); accept(c);
    request(c, "R5"); request(a, "R5"); request(b, "R5");

    // R6 absent number, and request in the same cycle as its accept
    request(8'h77, "R6");
    a = 8'(idc);
    step(CH'($urandom), 1'b1, 1'b1, a, "R6"); drain();
    request(a, "R3");

    // R2 latency extremes
    lat_cfg = 4'd15; accept(a); request(a, "R2");
    lat_cfg = 4'd1;  accept(a); request(a, "R2");
    lat_cfg = 4'd7;  idle(8);

    // R7 backpressure and ignored request while busy
    accept(a); accept(b);
    evt_ready = 1'b0;
    step(CH'($urandom), 1'b0, 1'b1, a, "R7");
    chk(evt_valid == 1'b1, "R4", "valid one cycle after request", 64'(evt_valid), 64'h1);
    chk(evt_id == a, "R4", "id one cycle after request", 64'(evt_id), 64'(a));
    c = evt_id; d = {7'd0, evt_miss};
    for (int i = 0; i < 3; i++) begin
      step(CH'($urandom), 1'b0, i == 1, b, "R7");
      chk(evt_valid == 1'b1 && evt_id == c && evt_miss == d[0], "R7", "held output",
          64'({evt_valid, evt_id}), 64'({1'b1, c}));
    end
    evt_ready = 1'b1; drain(); idle(3);
    chk(evt_valid == 1'b0, "R7", "no event from ignored request", 64'(evt_valid), 64'h0);
    request(b, "R7");

    // R8 fill, discard, sticky flag; R9 tag advances past the discard
    for (int i = 0; i < 5; i++) accept(ids[i]);
    chk(overflow == exp_ovf && exp_ovf, "R8", "overflow after discard", 64'(overflow), 64'h1);
    request(ids[4], "R9");
    for (int i = 0; i < 4; i++) request(ids[i], "R8");
    chk(overflow == 1'b1, "R8", "overflow still set", 64'(overflow), 64'h1);
    accept(a);
    chk(a == 8'(ids[4] + 8'd1), "R9", "tag after discard", 64'(a), 64'(ids[4] + 8'd1));

    // R10 freed only on handshake, then miss, then reuse
    request(a, "R10");
    request(a, "R10");
    accept(b); request(b, "R10");

    // R9 tag wrap
    for (int i = 0; i < 260; i++) begin
      accept(a);
      request(a, "R9");
    end

    // R11 mid-run reset
    accept(a); accept(b);
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    k = 0; idc = 0; exp_ovf = 1'b0; model.delete(); hist.delete();
    chk(overflow == 1'b0, "R11", "overflow cleared", 64'(overflow), 64'h0);
    chk(evt_valid == 1'b0, "R11", "output cleared", 64'(evt_valid), 64'h0);
    idle(10);
    request(8'd0, "R11");
    accept(a);
    chk(a == 8'd0, "R11", "tag restarts", 64'(a), 64'h0);
    request(a, "R11");

    drain();
    chk(sbq.size() == 0, "R4", "all expected events seen", 64'(sbq.size()), 64'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule